// File: doc/BRIEF.md
# Shared Interrupt CPU-Target Register File

This block keeps the CPU routing choice for every shared interrupt of an interrupt controller. Software reaches it through a word-wide register access port. Each 32-bit word covers four consecutive interrupts, one byte per interrupt. A target byte that software writes may name any set of CPUs. The block turns that byte into exactly one owning CPU and stores only that CPU's index.

From the stored indices the block drives a flat per-CPU mask: for every shared interrupt, exactly one CPU's bit is set. Downstream pending logic can then gate each interrupt to a single core. Reads rebuild the byte view from the stored index. The words covering the first 32 interrupts belong to the per-CPU private interrupts. They are fixed: they read back the accessing CPU and ignore writes. After each accepted write the block raises a one-cycle update pulse, so that the pending logic knows to re-evaluate.

Top module: `irq_target_router`

## Requirements
- R1: After reset every shared interrupt is owned by CPU 0: every shared word reads 0x01 in each byte, and only the CPU 0 mask bits are set.
- R2: Word w covers interrupts 4w to 4w+3, with interrupt 4w+i held in bits [8i+7:8i]. Words 0 to 7 cover the 32 private interrupts, and word 8 onward covers the shared ones.
- R3: On a write to a shared word, each byte selects as owner the CPU whose bit is the lowest set bit of that byte.
- R4: A target byte with no usable bit set selects CPU 0.
- R5: Byte bits at positions equal to or above NUM_CPUS are ignored when the owner is chosen (default NUM_CPUS is 4, so bits 7:4 have no effect).
- R6: For each shared interrupt s, `tgt_mask` bit c*NUM_SHARED+s is set only for the owning CPU c, so each interrupt has exactly one bit set.
- R7: A read of a private word returns, in every byte, a one-hot value with bit `acc_cpu` set.
- R8: Writes to private words change no stored target, leave `tgt_mask` unchanged and raise no update pulse.
- R9: A read of a shared word returns, in each byte, a single bit at the index of that interrupt's owner. The read data is combinational in the same cycle as the access, and is zero when no access is requested.
- R10: `upd_pulse` is high for exactly the one cycle after each accepted shared write, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access requested this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | WORD_W | Word index within the target register space |
| acc_cpu | input | CPU_W | Index of the CPU performing the access |
| acc_wdata | input | 32 | Write data, one target byte per interrupt |
| acc_rdata | output | 32 | Read data, combinational |
| upd_pulse | output | 1 | One-cycle pulse after an accepted shared write |
| tgt_mask | output | NUM_CPUS*NUM_SHARED | Per-CPU one-hot routing mask, bit c*NUM_SHARED+s |

## Verification
The assertions assume that `acc_cpu` always names an existing CPU, below NUM_CPUS, whenever `acc_valid` is high. They also assume that the access inputs are held low during reset, because the pulse checks look one cycle back across the reset release. The bench drives `acc_cpu` only with values from 0 to NUM_CPUS-1 and keeps `acc_valid` low except during its single-cycle access tasks. Its write data covers bytes with several bits set, bytes that are all zero, and bytes whose only set bits lie above the CPU count.

// File: rtl/irq_route_pkg.sv
// Package: constants shared by the interrupt target router modules.
// Assumes the private interrupt range is a fixed 32 interrupts (8 words).
package irq_route_pkg;
    localparam int PRIV_IRQS  = 32;
    localparam int IRQS_WORD  = 4;
    localparam int PRIV_WORDS = PRIV_IRQS / IRQS_WORD;
    localparam int BYTE_W     = 8;
endpackage

// File: rtl/route_pick.sv
// Module: route_pick
// Reduces one 8-bit target byte to a single CPU index: the lowest set bit
// among the first NUM_CPUS bits, or CPU 0 when none of them is set.
// Assumes NUM_CPUS is between 1 and 8.
module route_pick #(
    parameter int NUM_CPUS = 4,
    parameter int CPU_W    = 2
) (
    input  logic [7:0]       byte_in,
    output logic [CPU_W-1:0] cpu_idx
);
    logic found;

    // Scan upward and keep the first usable set bit.
    always_comb begin
        cpu_idx = '0;
        found   = 1'b0;
        for (int b = 0; b < NUM_CPUS; b++) begin
            if (!found && byte_in[b]) begin
                cpu_idx = CPU_W'(b);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/route_store.sv
// Module: route_store
// Holds the owning CPU index of every shared interrupt and expands it into a
// per-CPU one-hot mask. One write updates the four interrupts of one word.
// Assumes wr_group addresses a valid shared word when wr_en is high.
module route_store #(
    parameter int NUM_CPUS   = 4,
    parameter int CPU_W      = 2,
    parameter int NUM_SHARED = 32,
    parameter int GRP_W      = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [GRP_W-1:0]                   wr_group,
    input  logic [3:0][CPU_W-1:0]              wr_idx,
    output logic [NUM_SHARED-1:0][CPU_W-1:0]   tgt_q,
    output logic [NUM_CPUS*NUM_SHARED-1:0]     tgt_mask
);
    // Store the four new owners of the addressed word; reset gives CPU 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < 4; i++) begin
                if (int'(wr_group) * 4 + i < NUM_SHARED)
                    tgt_q[int'(wr_group) * 4 + i] <= wr_idx[i];
            end
        end
    end

    // Expand each stored index into one bit per CPU.
    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_irq
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            assign tgt_mask[c*NUM_SHARED + s] = (tgt_q[s] == CPU_W'(c));
        end
    end
endmodule

// File: rtl/route_readback.sv
// Module: route_readback
// Builds the 32-bit read view: a fixed one-hot pattern of the accessing CPU
// for private words, the owner's one-hot byte for shared words, and zero
// for words beyond the range or when no access is requested.
module route_readback #(
    parameter int NUM_WORDS  = 16,
    parameter int WORD_W     = 4,
    parameter int CPU_W      = 2,
    parameter int NUM_SHARED = 32
) (
    input  logic                             rd_valid,
    input  logic [WORD_W-1:0]                rd_word,
    input  logic [CPU_W-1:0]                 rd_cpu,
    input  logic [NUM_SHARED-1:0][CPU_W-1:0] tgt_q,
    output logic [31:0]                      rdata
);
    import irq_route_pkg::*;

    // Select the byte source by word region.
    always_comb begin
        rdata = '0;
        if (rd_valid) begin
            if (int'(rd_word) < PRIV_WORDS) begin
                for (int i = 0; i < 4; i++)
                    rdata[8*i +: 8] = 8'(1) << rd_cpu;
            end else if (int'(rd_word) < NUM_WORDS) begin
                for (int i = 0; i < 4; i++) begin
                    if ((int'(rd_word) - PRIV_WORDS) * 4 + i < NUM_SHARED)
                        rdata[8*i +: 8] = 8'(1) << tgt_q[(int'(rd_word) - PRIV_WORDS) * 4 + i];
                end
            end
        end
    end
endmodule

// File: rtl/irq_target_router.sv
// Module: irq_target_router (top)
// Register file of single-target CPU routing for shared interrupts. Writes
// to shared words reduce each byte to one owner and pulse upd_pulse one
// cycle later; private words are read-only and reflect the accessing CPU.
// Assumes NUM_IRQS is a multiple of 4 above 32 and NUM_CPUS is 1 to 8.
module irq_target_router #(
    parameter int NUM_CPUS   = 4,
    parameter int NUM_IRQS   = 64,
    localparam int CPU_W      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int NUM_WORDS  = NUM_IRQS / 4,
    localparam int WORD_W     = $clog2(NUM_WORDS),
    localparam int NUM_SHARED = NUM_IRQS - 32,
    localparam int SH_WORDS   = NUM_SHARED / 4,
    localparam int GRP_W      = (SH_WORDS > 1) ? $clog2(SH_WORDS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_valid,
    input  logic                           acc_write,
    input  logic [WORD_W-1:0]              acc_word,
    input  logic [CPU_W-1:0]               acc_cpu,
    input  logic [31:0]                    acc_wdata,
    output logic [31:0]                    acc_rdata,
    output logic                           upd_pulse,
    output logic [NUM_CPUS*NUM_SHARED-1:0] tgt_mask
);
    import irq_route_pkg::*;

    logic                             sh_wr;
    logic [GRP_W-1:0]                 sh_group;
    logic [3:0][CPU_W-1:0]            pick_idx;
    logic [NUM_SHARED-1:0][CPU_W-1:0] tgt_q;

    // Accept a write only when it lands in the shared region.
    assign sh_wr    = acc_valid && acc_write &&
                      (int'(acc_word) >= PRIV_WORDS) && (int'(acc_word) < NUM_WORDS);
    assign sh_group = GRP_W'(int'(acc_word) - PRIV_WORDS);

    // One lowest-bit reducer per target byte.
    for (genvar i = 0; i < 4; i++) begin : g_pick
        route_pick #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_pick (
            .byte_in (acc_wdata[8*i +: 8]),
            .cpu_idx (pick_idx[i])
        );
    end

    route_store #(
        .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
        .NUM_SHARED(NUM_SHARED), .GRP_W(GRP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sh_wr),
        .wr_group (sh_group),
        .wr_idx   (pick_idx),
        .tgt_q    (tgt_q),
        .tgt_mask (tgt_mask)
    );

    route_readback #(
        .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
        .CPU_W(CPU_W), .NUM_SHARED(NUM_SHARED)
    ) u_rd (
        .rd_valid (acc_valid && !acc_write),
        .rd_word  (acc_word),
        .rd_cpu   (acc_cpu),
        .tgt_q    (tgt_q),
        .rdata    (acc_rdata)
    );

    // Flag each accepted shared write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pulse <= 1'b0;
        else        upd_pulse <= sh_wr;
    end
endmodule

// File: rtl/irq_target_router_chk.sv
// Module: irq_target_router_chk
// Property checker for irq_target_router, attached by bind below.
// Assumes acc_cpu < NUM_CPUS while acc_valid is high.
module irq_target_router_chk #(
    parameter int NUM_CPUS   = 4,
    parameter int NUM_IRQS   = 64,
    localparam int CPU_W      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int NUM_WORDS  = NUM_IRQS / 4,
    localparam int WORD_W     = $clog2(NUM_WORDS),
    localparam int NUM_SHARED = NUM_IRQS - 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           acc_valid,
    input logic                           acc_write,
    input logic [WORD_W-1:0]              acc_word,
    input logic [CPU_W-1:0]               acc_cpu,
    input logic [31:0]                    acc_wdata,
    input logic [31:0]                    acc_rdata,
    input logic                           upd_pulse,
    input logic [NUM_CPUS*NUM_SHARED-1:0] tgt_mask
);
    logic priv_acc;
    logic sh_acc;
    assign priv_acc = acc_valid && (int'(acc_word) < 8);
    assign sh_acc   = acc_valid && (int'(acc_word) >= 8) && (int'(acc_word) < NUM_WORDS);

    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_one
        logic [NUM_CPUS-1:0] col;
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_col
            assign col[c] = tgt_mask[c*NUM_SHARED + s];
        end
        AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) == 1); // R6
    end

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_acc && acc_write) |=> upd_pulse); // R10
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_acc && acc_write) |=> !upd_pulse); // R10
    AST_PRIV_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_acc && acc_write) |=> !upd_pulse); // R8
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_acc && acc_write) |=> $stable(tgt_mask)); // R8
    AST_PRIV_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_acc && !acc_write) |-> (acc_rdata == {4{8'(1) << acc_cpu}})); // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_rdata == 32'h0)); // R9
endmodule

bind irq_target_router irq_target_router_chk #(
    .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)
) u_chk (.*);

// File: tb/test_irq_target_router.sv
// Directed bench for irq_target_router; default parameters (4 CPUs, 64 IRQs).
module test_irq_target_router;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NIRQ = 64;
    localparam int NSH  = NIRQ - 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_valid, acc_write;
    logic [3:0]       acc_word;
    logic [1:0]       acc_cpu;
    logic [31:0]      acc_wdata, acc_rdata;
    logic             upd_pulse;
    logic [NCPU*NSH-1:0] tgt_mask;

    int n_chk = 0, n_fail = 0;
    int exp_tgt [NSH];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_target_router #(.NUM_CPUS(NCPU), .NUM_IRQS(NIRQ)) i_irq_target_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .upd_pulse(upd_pulse), .tgt_mask(tgt_mask)
    );

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference owner choice: lowest set bit below NCPU, else CPU 0.
    function automatic int ref_pick(logic [7:0] b);
        for (int k = 0; k < NCPU; k++) if (b[k]) return k;
        return 0;
    endfunction

    function automatic logic [NCPU*NSH-1:0] ref_mask();
        logic [NCPU*NSH-1:0] m = '0;
        for (int s = 0; s < NSH; s++) m[exp_tgt[s]*NSH + s] = 1'b1;
        return m;
    endfunction

    task automatic rd_word(int w, int cpu, logic [31:0] exp, string req);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_word = 4'(w); acc_cpu = 2'(cpu);
        #1 check(req, 128'(acc_rdata), 128'(exp));
        @(negedge clk);
        acc_valid = 0;
        check({req, " no pulse on read"}, 128'(upd_pulse), 128'(0));
    endtask

    task automatic wr_word(int w, logic [31:0] d, bit shared);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_word = 4'(w); acc_wdata = d; acc_cpu = 2'd1;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        check("R10 pulse after write", 128'(upd_pulse), 128'(shared));
        if (shared)
            for (int i = 0; i < 4; i++) exp_tgt[(w-8)*4 + i] = ref_pick(d[8*i +: 8]);
        @(negedge clk);
        check("R10 pulse one cycle", 128'(upd_pulse), 128'(0));
        check("R6 mask one-hot per irq", 128'(tgt_mask), 128'(ref_mask()));
    endtask

    function automatic logic [31:0] ref_word(int w);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = 8'(1) << exp_tgt[(w-8)*4 + i];
        return r;
    endfunction

    task automatic t_reset();
        for (int s = 0; s < NSH; s++) exp_tgt[s] = 0;
        check("R1 reset mask", 128'(tgt_mask), 128'(ref_mask()));
        check("R1 reset pulse", 128'(upd_pulse), 128'(0));
        for (int w = 8; w < 16; w++) rd_word(w, 0, 32'h01010101, "R1 reset read");
    endtask

    task automatic t_private();
        for (int c = 0; c < NCPU; c++)
            rd_word(c*2, c, {4{8'(1) << c}}, "R7 private read");
        wr_word(3, 32'hFFFFFFFF, 0);
        rd_word(3, 2, 32'h04040404, "R8 private write ignored");
    endtask

    task automatic t_lowest();
        wr_word(8, 32'h880C0603, 1);
        rd_word(8, 0, 32'h08040201, "R3 R2 R9 lowest bit");
        check("R3 model", 128'(ref_word(8)), 128'(32'h08040201));
    endtask

    task automatic t_zero_high();
        wr_word(9, 32'h00F00000, 1);
        rd_word(9, 3, 32'h01010101, "R4 R5 zero and high bits");
        wr_word(15, 32'h08002002, 1);
        rd_word(15, 1, 32'h08010102, "R5 R2 last word");
        rd_word(8, 1, ref_word(8), "R9 other word kept");
    endtask

    initial begin
        acc_valid = 0; acc_write = 0; acc_word = '0; acc_cpu = '0; acc_wdata = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_private();
        t_lowest();
        t_zero_high();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule